// File: doc/BRIEF.md
# Dual-Plane Frame Buffer Lane Mapper

This block sits between a 16-bit CPU bus and the request port of a 16-bit SDRAM controller. The CPU sees two separate pixel planes, one byte per pixel: a static plane and a dynamic plane. The top address bit picks the plane. Each plane covers 640 x 480 pixel positions.

Every SDRAM word stores one pixel position. The 5-bit static part of the pixel lives in the upper byte of the word. The 3-bit dynamic part lives in the lower byte. On writes, the mapper moves the relevant bits of each CPU pixel byte onto the lane that belongs to the plane, zeroes everything else and strobes only that lane. On reads, it fetches both lanes, keeps the bits that belong to the addressed plane and zeroes the rest.

A CPU word carries two pixels. The mapper turns each access into zero, one or two SDRAM word operations, in order. It then reports completion with a single ready pulse.

Top module: `fbuf_plane_mapper`

## Requirements
- R1: While reset is high and in the first cycle after it, `cpu_ready` and `sd_req` are 0.
- R2: A static-plane write (`cpu_addr[19]`=0) issues `sd_be`=2'b10 with `sd_wdata[15:8]` = pixel AND 8'hF8 and `sd_wdata[7:0]` = 0.
- R3: A dynamic-plane write (`cpu_addr[19]`=1) issues `sd_be`=2'b01 with `sd_wdata[7:0]` = pixel AND 8'h07 and `sd_wdata[15:8]` = 0.
- R4: A read issues `sd_be`=2'b11 and `sd_wdata`=0. A static-plane pixel returns `sd_rdata[15:8]` AND 8'hF8. A dynamic-plane pixel returns `sd_rdata[7:0]` AND 8'h07. All other bits of the SDRAM word are ignored.
- R5: `sd_addr` equals `cpu_addr[18:1]` with bit 0 replaced by the pixel slot: 0 for the pixel in CPU bits [15:8], 1 for the pixel in CPU bits [7:0]. `cpu_addr[0]` is ignored.
- R6: A single-byte access (`cpu_be`=2'b10 selects the [15:8] pixel, 2'b01 selects the [7:0] pixel) performs exactly one SDRAM operation.
- R7: A two-byte write (`cpu_be`=2'b11) performs two SDRAM writes to consecutive words. Slot 0 goes first, then slot 1.
- R8: A two-byte read packs the slot-0 pixel into `cpu_rdata[15:8]` and the slot-1 pixel into `cpu_rdata[7:0]`. After a single-byte read, the unselected byte of `cpu_rdata` is 0.
- R9: `cpu_ready` is high for exactly one cycle after the last SDRAM operation of an access completes. A `cpu_req` that arrives while an access is in progress is ignored.
- R10: An access with `cpu_be`=2'b00 performs no SDRAM operation and returns ready with `cpu_rdata`=0.
- R11: `sd_req`, `sd_addr`, `sd_be` and `sd_wdata` stay stable from the cycle `sd_req` rises until `sd_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, sampled only when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 20 | Byte address; bit 19 selects the plane |
| cpu_be | input | 2 | Pixel enables: bit 1 = slot 0 [15:8], bit 0 = slot 1 [7:0] |
| cpu_wdata | input | 16 | Two pixel bytes to write |
| cpu_rdata | output | 16 | Two pixel bytes read, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| sd_req | output | 1 | SDRAM word operation request |
| sd_we | output | 1 | SDRAM write when 1 |
| sd_addr | output | 19 | SDRAM word address |
| sd_be | output | 2 | Lane strobes: bit 1 static lane, bit 0 dynamic lane |
| sd_wdata | output | 16 | SDRAM write word |
| sd_rdata | input | 16 | SDRAM read word, valid with sd_ack |
| sd_ack | input | 1 | One-cycle completion of the current SDRAM operation |

## Verification
The hardest situation to reach is a second CPU request that lands while a two-pixel burst is stalled between its SDRAM operations. Such a request must leave no trace. The bench's memory model withholds its acknowledge at random. Immediately after a burst starts, the bench fires an intruding write to a different pixel. It then reads that pixel back through the CPU port and confirms its old value. SDRAM words are also preloaded with junk in the bits that do not belong to either plane, so any leakage in the read masking appears in `cpu_rdata`.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;

    localparam int PIX_W  = 8;
    localparam int WORD_W = 16;
    localparam int ST_W   = 5;
    localparam int DY_W   = 3;

    localparam logic [PIX_W-1:0] ST_MASK = 8'hF8;
    localparam logic [PIX_W-1:0] DY_MASK = 8'h07;

    localparam logic [1:0] BE_STATIC = 2'b10;
    localparam logic [1:0] BE_DYN    = 2'b01;
    localparam logic [1:0] BE_BOTH   = 2'b11;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_XFER = 2'd1,
        S_DONE = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [1:0]        be;
        logic [WORD_W-1:0] data;
    } lane_word_t;

    // Place a pixel byte on the lane owned by its plane.
    function automatic lane_word_t pack_pixel(input logic we, input logic plane,
                                              input logic [PIX_W-1:0] pix);
        lane_word_t w;
        if (!we) begin
            w.be   = BE_BOTH;
            w.data = '0;
        end else if (plane) begin
            w.be   = BE_DYN;
            w.data = {8'h00, pix & DY_MASK};
        end else begin
            w.be   = BE_STATIC;
            w.data = {pix & ST_MASK, 8'h00};
        end
        return w;
    endfunction

    // Keep only the plane's own bits of a returned SDRAM word.
    function automatic logic [PIX_W-1:0] unpack_pixel(input logic plane,
                                                      input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] m;
        m = w & (plane ? {8'h00, DY_MASK} : {ST_MASK, 8'h00});
        return m[15:8] | m[7:0];
    endfunction

endpackage

// File: rtl/fbuf_wr_lane.sv
module fbuf_wr_lane
    import fbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              op_we,
    input  logic              op_plane,
    input  logic [PIX_W-1:0]  op_pix,
    output logic [1:0]        lane_be,
    output logic [WORD_W-1:0] lane_data
);
    lane_word_t lw;

    always_comb begin
        lw        = pack_pixel(op_we, op_plane, op_pix);
        lane_be   = lw.be;
        lane_data = lw.data;
    end

    // R2: static writes touch only the upper lane, low bits zero
    a_r2_static_lane: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_we && !op_plane) |-> (lane_be == 2'b10 && lane_data[10:0] == 11'd0));

    // R3: dynamic writes touch only the lower lane, upper bits zero
    a_r3_dyn_lane: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_we && op_plane) |-> (lane_be == 2'b01 && lane_data[15:3] == 13'd0));

endmodule

// File: rtl/fbuf_rd_lane.sv
module fbuf_rd_lane
    import fbuf_pkg::*;
(
    input  logic              plane,
    input  logic [WORD_W-1:0] sd_word,
    output logic [PIX_W-1:0]  pix
);
    always_comb pix = unpack_pixel(plane, sd_word);
endmodule

// File: rtl/fbuf_seq.sv
module fbuf_seq
    import fbuf_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_plane,
    input  logic [AW-1:0]     cpu_idx,
    input  logic [1:0]        cpu_be,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              op_valid,
    output logic              op_we,
    output logic              op_plane,
    output logic [AW-1:0]     op_addr,
    output logic [PIX_W-1:0]  op_pix,
    input  logic              op_ack,
    input  logic [PIX_W-1:0]  rd_pix
);
    localparam logic [AW-1:0] EVEN_MASK = ~AW'(1);

    seq_state_t        state_q;
    logic              we_q;
    logic              plane_q;
    logic [AW-1:0]     idx_q;
    logic [1:0]        be_q;
    logic [WORD_W-1:0] wdata_q;
    logic              slot_q;
    logic [WORD_W-1:0] rdata_q;
    logic              last_op;

    assign last_op = !(be_q == 2'b11 && !slot_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            we_q    <= 1'b0;
            plane_q <= 1'b0;
            idx_q   <= '0;
            be_q    <= '0;
            wdata_q <= '0;
            slot_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (cpu_req) begin
                        we_q    <= cpu_we;
                        plane_q <= cpu_plane;
                        idx_q   <= cpu_idx;
                        be_q    <= cpu_be;
                        wdata_q <= cpu_wdata;
                        rdata_q <= '0;
                        slot_q  <= ~cpu_be[1];
                        state_q <= (cpu_be == 2'b00) ? S_DONE : S_XFER;
                    end
                end
                S_XFER: begin
                    if (op_ack) begin
                        if (!we_q) begin
                            if (slot_q) rdata_q[7:0]  <= rd_pix;
                            else        rdata_q[15:8] <= rd_pix;
                        end
                        if (last_op) state_q <= S_DONE;
                        else         slot_q  <= 1'b1;
                    end
                end
                S_DONE:  state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        op_valid  = (state_q == S_XFER);
        op_we     = we_q;
        op_plane  = plane_q;
        op_addr   = (idx_q & EVEN_MASK) | AW'(slot_q);
        op_pix    = slot_q ? wdata_q[7:0] : wdata_q[15:8];
        cpu_ready = (state_q == S_DONE);
        cpu_rdata = rdata_q;
    end

    // R11: a pending SDRAM request holds still until acknowledged
    a_r11_hold_req: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_ack) |=> (op_valid && $stable(op_addr) && $stable(op_pix)
                                   && $stable(op_we) && $stable(op_plane)));

    // R9: ready lasts a single cycle
    a_r9_one_pulse: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);

    // R9: ready only once no SDRAM operation is outstanding
    a_r9_ready_quiet: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> !op_valid);

endmodule

// File: rtl/fbuf_plane_mapper.sv
module fbuf_plane_mapper
    import fbuf_pkg::*;
#(
    parameter int CPU_AW = 20,
    parameter int SD_AW  = CPU_AW - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [1:0]        cpu_be,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    output logic              cpu_ready,
    output logic              sd_req,
    output logic              sd_we,
    output logic [SD_AW-1:0]  sd_addr,
    output logic [1:0]        sd_be,
    output logic [15:0]       sd_wdata,
    input  logic [15:0]       sd_rdata,
    input  logic              sd_ack
);
    logic             op_valid;
    logic             op_we;
    logic             op_plane;
    logic [SD_AW-1:0] op_addr;
    logic [PIX_W-1:0] op_pix;
    logic [PIX_W-1:0] rd_pix;

    fbuf_seq #(.AW(SD_AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_plane (cpu_addr[CPU_AW-1]),
        .cpu_idx   (cpu_addr[SD_AW-1:0]),
        .cpu_be    (cpu_be),
        .cpu_wdata (cpu_wdata),
        .cpu_ready (cpu_ready),
        .cpu_rdata (cpu_rdata),
        .op_valid  (op_valid),
        .op_we     (op_we),
        .op_plane  (op_plane),
        .op_addr   (op_addr),
        .op_pix    (op_pix),
        .op_ack    (sd_ack),
        .rd_pix    (rd_pix)
    );

    fbuf_wr_lane u_wr (
        .clk       (clk),
        .rst       (rst),
        .op_valid  (op_valid),
        .op_we     (op_we),
        .op_plane  (op_plane),
        .op_pix    (op_pix),
        .lane_be   (sd_be),
        .lane_data (sd_wdata)
    );

    fbuf_rd_lane u_rd (
        .plane   (op_plane),
        .sd_word (sd_rdata),
        .pix     (rd_pix)
    );

    assign sd_req  = op_valid;
    assign sd_we   = op_we;
    assign sd_addr = op_addr;

endmodule

// File: tb/fbuf_plane_mapper_tb.sv
module fbuf_plane_mapper_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [19:0] cpu_addr = '0;
    logic [1:0]  cpu_be = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        sd_req;
    logic        sd_we;
    logic [18:0] sd_addr;
    logic [1:0]  sd_be;
    logic [15:0] sd_wdata;
    logic [15:0] sd_rdata = '0;
    logic        sd_ack = 1'b0;

    always #4 clk = ~clk;

    fbuf_plane_mapper u_dut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .sd_req(sd_req), .sd_we(sd_we), .sd_addr(sd_addr), .sd_be(sd_be),
        .sd_wdata(sd_wdata), .sd_rdata(sd_rdata), .sd_ack(sd_ack)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    bit stall_en = 0;
    logic prev_ready = 1'b0;

    logic [15:0] mem     [int];
    logic [15:0] ref_mem [int];

    typedef struct packed {
        logic        we;
        logic [18:0] addr;
        logic [1:0]  be;
        logic [15:0] data;
    } exp_op_t;
    exp_op_t exp_q[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_rd(input int i);
        return ref_mem.exists(i) ? ref_mem[i] : 16'h0000;
    endfunction

    // SDRAM stand-in: acknowledges a held request, optionally after a random stall
    always @(posedge clk) begin
        if (rst) begin
            sd_ack <= 1'b0;
        end else if (sd_req && !sd_ack && (!stall_en || ($urandom % 3) != 0)) begin
            sd_ack <= 1'b1;
            if (sd_we) begin
                logic [15:0] w;
                w = mem.exists(int'(sd_addr)) ? mem[int'(sd_addr)] : 16'h0000;
                if (sd_be[1]) w[15:8] = sd_wdata[15:8];
                if (sd_be[0]) w[7:0]  = sd_wdata[7:0];
                mem[int'(sd_addr)] = w;
            end else begin
                sd_rdata <= mem.exists(int'(sd_addr)) ? mem[int'(sd_addr)] : 16'h0000;
            end
        end else begin
            sd_ack <= 1'b0;
        end
    end

    // Per-clock comparison against the expected operation stream
    always @(negedge clk) begin
        if (!rst) begin
            if (sd_ack) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected SDRAM op", {12'h0, sd_addr, sd_we}, 32'h0);
                end else begin
                    exp_op_t e;
                    e = exp_q.pop_front();
                    check(sd_addr == e.addr, "R5/R7 sd_addr", 32'(sd_addr), 32'(e.addr));
                    check(sd_we == e.we && sd_be == e.be, "R2/R3/R4 sd_be", {sd_we, sd_be},
                          {e.we, e.be});
                    check(sd_wdata == e.data, "R2/R3/R4 sd_wdata", 32'(sd_wdata), 32'(e.data));
                end
            end
            if (prev_ready && cpu_ready)
                check(1'b0, "R9 ready longer than one cycle", 32'd1, 32'd0);
            prev_ready = cpu_ready;
        end
    end

    task automatic access(input logic we, input logic [19:0] addr, input logic [1:0] be,
                          input logic [15:0] wd, input bit intrude, input logic [19:0] iaddr);
        logic [15:0] exp_rd;
        logic        plane;
        int          guard;
        exp_rd = '0;
        plane  = addr[19];
        for (int s = 0; s < 2; s++) begin
            if (be[1-s]) begin
                exp_op_t e;
                logic [7:0] pix;
                int i;
                e.addr = {addr[18:1], s[0]};
                i = int'(e.addr);
                e.we = we;
                pix = (s == 0) ? wd[15:8] : wd[7:0];
                if (we) begin
                    logic [15:0] r;
                    r = ref_rd(i);
                    if (plane) begin
                        e.be = 2'b01; e.data = {8'h00, pix & 8'h07};
                        r[7:0] = pix & 8'h07;
                    end else begin
                        e.be = 2'b10; e.data = {pix & 8'hF8, 8'h00};
                        r[15:8] = pix & 8'hF8;
                    end
                    ref_mem[i] = r;
                end else begin
                    logic [7:0] rp;
                    e.be = 2'b11; e.data = 16'h0000;
                    rp = plane ? (ref_rd(i)[7:0] & 8'h07) : (ref_rd(i)[15:8] & 8'hF8);
                    if (s == 0) exp_rd[15:8] = rp; else exp_rd[7:0] = rp;
                end
                exp_q.push_back(e);
            end
        end
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_be = be; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        if (intrude) begin
            cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = iaddr; cpu_be = 2'b11; cpu_wdata = 16'hFFFF;
            @(negedge clk);
            cpu_req = 1'b0;
        end
        guard = 0;
        while (!cpu_ready && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(cpu_ready, "R9 ready never arrived", 32'(cpu_ready), 32'd1);
        check(exp_q.size() == 0, "R6/R7 SDRAM op count", 32'(exp_q.size()), 32'd0);
        if (!we) check(cpu_rdata == exp_rd, "R4/R8/R10 cpu_rdata", 32'(cpu_rdata), 32'(exp_rd));
        exp_q.delete();
        @(negedge clk);
    endtask

    task automatic preload(input int i, input logic [15:0] v);
        mem[i] = v;
        ref_mem[i] = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs during reset
        check(!cpu_ready && !sd_req, "R1 outputs in reset", {cpu_ready, sd_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!cpu_ready && !sd_req, "R1 outputs after reset", {cpu_ready, sd_req}, 32'd0);

        for (int i = 0; i < 32; i++) preload(i, 16'(($urandom & 32'hFFFF)));
        preload(307198, 16'h5A5A);
        preload(307199, 16'hA5A5);

        // R4: junk in unused bits is masked on both planes
        access(1'b0, 20'h00004, 2'b11, 16'h0, 1'b0, 20'h0);
        access(1'b0, 20'h80004, 2'b11, 16'h0, 1'b0, 20'h0);
        // R2 R6: single static write, slot 0; R8 single read
        access(1'b1, 20'h00010, 2'b10, 16'hFF00, 1'b0, 20'h0);
        access(1'b0, 20'h00010, 2'b10, 16'h0, 1'b0, 20'h0);
        // R3 R6: single dynamic write, slot 1, odd address bit ignored (R5)
        access(1'b1, 20'h80011, 2'b01, 16'h00FF, 1'b0, 20'h0);
        access(1'b0, 20'h80010, 2'b01, 16'h0, 1'b0, 20'h0);
        // R7 R8: two-pixel write then reads on both planes
        access(1'b1, 20'h00020, 2'b11, 16'hC3A7, 1'b0, 20'h0);
        access(1'b0, 20'h00020, 2'b11, 16'h0, 1'b0, 20'h0);
        access(1'b0, 20'h80020, 2'b11, 16'h0, 1'b0, 20'h0);
        // R10: empty enable
        access(1'b0, 20'h00006, 2'b00, 16'h0, 1'b0, 20'h0);
        access(1'b1, 20'h00006, 2'b00, 16'hFFFF, 1'b0, 20'h0);
        access(1'b0, 20'h00006, 2'b11, 16'h0, 1'b0, 20'h0);
        // R5: highest pixel position of a plane
        access(1'b1, 20'hCAFFF, 2'b11, 16'h1234, 1'b0, 20'h0);
        access(1'b0, 20'hCAFFE, 2'b11, 16'h0, 1'b0, 20'h0);
        access(1'b0, 20'h4AFFE, 2'b11, 16'h0, 1'b0, 20'h0);

        stall_en = 1;
        // R9 R11: intruding request during a stalled burst is ignored
        access(1'b1, 20'h00040, 2'b11, 16'h8181, 1'b1, 20'h80008);
        access(1'b0, 20'h80008, 2'b11, 16'h0, 1'b0, 20'h0);
        access(1'b1, 20'h80042, 2'b11, 16'h7E7E, 1'b1, 20'h0000A);
        access(1'b0, 20'h0000A, 2'b11, 16'h0, 1'b0, 20'h0);

        for (int k = 0; k < 300; k++) begin
            logic [19:0] a;
            a = {($urandom % 2) == 1, 14'h0, 5'(($urandom % 32))};
            access(($urandom % 2) == 1, a, 2'(($urandom % 4)), 16'(($urandom & 32'hFFFF)),
                   1'b0, 20'h0);
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule